// File: doc/BRIEF.md
# Link Output Frame Serializer for a Shared Audio Codec Link

This block sits on the controller side of a serial audio codec link. It runs from the bit clock that the link supplies. Every 256 bit clocks it sends one output frame on a single data line and marks the 16-bit tag slot with a frame strobe. Each frame holds a tag slot, a command address slot, a command data slot, and the left and right playback sample slots. All later slots are sent as zeros.

Up to four codecs share the link, and a 2-bit codec identity selects one of them. A one-deep ready/valid port takes register read or write requests. The primary codec has identity 00. A request to it sets the command-valid tags and leaves the ID field at zero. A request to a secondary codec clears those tags and puts the codec identity in the ID field instead. A held request goes out in the next frame, and the request port then frees up. The left and right samples, with their valid flags, are sampled at each frame boundary.

Top module: `aclink_out_framer`

## Requirements
- R1: A frame is 256 bit clocks long. `sync` is high for exactly the first 16 bits of every frame. Both outputs change only on rising edges of `bit_clk`. Frames follow each other with no gap.
- R2: Bits go out MSB first: 16 tag bits, then 20-bit slots 1, 2, 3 and 4. Tag bit 15 is 1 when the frame carries a command or at least one valid sample. Bit 12 equals the left sample valid flag and bit 11 equals the right sample valid flag. Tag bits 10 down to 2 are 0.
- R3: A request with codec identity 00 sets tag bit 14 to 1. Tag bit 13 is 1 for a write and 0 for a read. Tag bits 1:0 are 00.
- R4: A request with codec identity 01, 10 or 11 drives tag bits 14 and 13 to 0 and places the identity in tag bits 1:0 of the same frame.
- R5: Slot 1 holds the read flag (1 = read) in bit 19, the 7-bit register address in bits 18:12, and zeros below. For a write, slot 2 holds the 16-bit write data in bits 19:4 and zeros in bits 3:0. For a read, slot 2 is zero.
- R6: Slot 3 carries `pcm_left` and slot 4 carries `pcm_right`. Each carries its sample only when the matching valid input is high at the frame boundary edge, and is zero otherwise.
- R7: Every bit after slot 4 (frame bits 96 to 255) is 0.
- R8: `req_ready` is high while no request is held. A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low, and further requests are ignored, until the held request has been loaded into a frame at the next frame boundary.
- R9: A frame with no pending request has tag bits 14, 13 and 1:0 at zero and slots 1 and 2 at zero.
- R10: While reset is asserted, `sync` and `sdata_out` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request holding slot is empty |
| req_read | input | 1 | 1 = read, 0 = write |
| req_codec | input | 2 | Target codec identity |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write data |
| pcm_left_valid | input | 1 | Left sample valid for the next frame |
| pcm_left | input | 20 | Left playback sample |
| pcm_right_valid | input | 1 | Right sample valid for the next frame |
| pcm_right | input | 20 | Right playback sample |
| sync | output | 1 | Frame strobe, high during the tag slot |
| sdata_out | output | 1 | Serial frame data |

## Verification
A request accepted during frame N appears in frame N+1. The payload of frame N+1 is also built from the sample inputs as they stand on the boundary edge that ends frame N. The bench therefore drives each stimulus one cycle after it sees a frame start. At that point it pushes the expected 96-bit payload into a queue. The monitor collects 256 samples from the next frame start onward, taking each on the falling edge that follows the rising edge that produced it, and compares them with the head of the queue. `req_ready` is checked on the falling edge right after the accepting edge, where it must be low, and again on the falling edge right after the next frame start, where it must be high.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int ID_W      = 2;
  localparam int PAYLOAD_W = TAG_W + 4 * SLOT_W;

  typedef struct packed {
    logic              rd;
    logic [ID_W-1:0]   codec;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } cmd_req_t;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int FRAME_BITS = 256,
  parameter int SYNC_BITS  = 16,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          load,
  output logic          sync_o,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] pos_q, pos_d;
  logic          sync_q, sync_d;

  always_comb begin
    load   = (pos_q == '0);
    pos_d  = (pos_q == PW'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
    sync_d = (pos_q < PW'(SYNC_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;
  assign pos_o  = pos_q;

  // R1: the strobe lasts exactly SYNC_BITS (16) bit clocks
  a_r1_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |-> ($past(sync_q, 16) && !$past(sync_q, 17)));
endmodule

// File: rtl/aclink_cmd_slots.sv
module aclink_cmd_slots
  import aclink_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  cmd_req_t             req,
  input  logic                 lv,
  input  logic [SLOT_W-1:0]    lsamp,
  input  logic                 rv,
  input  logic [SLOT_W-1:0]    rsamp,
  output logic [PAYLOAD_W-1:0] payload
);
  cmd_req_t    held_q, held_d;
  logic        held_v_q, held_v_d;
  logic        sec, wr, tag_a, tag_d, fvalid;
  logic [ID_W-1:0]   id_f;
  logic [TAG_W-1:0]  slot0;
  logic [SLOT_W-1:0] slot1, slot2, slot3, slot4;

  assign req_ready = !held_v_q;

  always_comb begin
    held_d   = held_q;
    held_v_d = held_v_q;
    if (load) held_v_d = 1'b0;
    if (req_valid && req_ready) begin
      held_d   = req;
      held_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      held_v_q <= 1'b0;
    end else begin
      held_q   <= held_d;
      held_v_q <= held_v_d;
    end
  end

  always_comb begin
    sec    = (held_q.codec != '0);
    wr     = !held_q.rd;
    tag_a  = held_v_q && !sec;
    tag_d  = held_v_q && !sec && wr;
    id_f   = (held_v_q && sec) ? held_q.codec : '0;
    fvalid = held_v_q || lv || rv;
    slot0  = {fvalid, tag_a, tag_d, lv, rv, 9'b0, id_f};
    slot1  = held_v_q ? {held_q.rd, held_q.addr, 12'b0} : '0;
    slot2  = (held_v_q && wr) ? {held_q.wdata, 4'b0} : '0;
    slot3  = lv ? lsamp : '0;
    slot4  = rv ? rsamp : '0;
    payload = {slot0, slot1, slot2, slot3, slot4};
  end

  // R8: an accepted request blocks the port on the next cycle
  a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8: a held request is released at the frame boundary
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !req_ready) |=> req_ready);
  // R4: secondary target clears command tags and carries its identity
  a_r4_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    (load && held_v_q && held_q.codec != '0) |->
      (payload[94:93] == 2'b00 && payload[81:80] == held_q.codec));
endmodule

// File: rtl/aclink_shifter.sv
module aclink_shifter #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par_in,
  output logic         ser_o
);
  logic [W-1:0] sh_q, sh_d;
  logic         bit_q, bit_d;

  always_comb begin
    if (load) begin
      bit_d = par_in[W-1];
      sh_d  = {par_in[W-2:0], 1'b0};
    end else begin
      bit_d = sh_q[W-1];
      sh_d  = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign ser_o = bit_q;
endmodule

// File: rtl/aclink_out_framer.sv
module aclink_out_framer
  import aclink_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SYNC_BITS  = TAG_W,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [ID_W-1:0]   req_codec,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pcm_left_valid,
  input  logic [SLOT_W-1:0] pcm_left,
  input  logic              pcm_right_valid,
  input  logic [SLOT_W-1:0] pcm_right,
  output logic              sync,
  output logic              sdata_out
);
  logic [1:0]           rs_q;
  logic                 rst_i;
  logic                 load;
  logic [PW-1:0]        pos;
  logic [PAYLOAD_W-1:0] payload;
  cmd_req_t             req;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign req = '{rd: req_read, codec: req_codec, addr: req_addr, wdata: req_wdata};

  aclink_frame_timer #(.FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS)) u_timer (
    .clk(bit_clk), .rst_n(rst_i), .load(load), .sync_o(sync), .pos_o(pos));

  aclink_cmd_slots u_slots (
    .clk(bit_clk), .rst_n(rst_i), .load(load),
    .req_valid(req_valid), .req_ready(req_ready), .req(req),
    .lv(pcm_left_valid), .lsamp(pcm_left),
    .rv(pcm_right_valid), .rsamp(pcm_right), .payload(payload));

  aclink_shifter #(.W(PAYLOAD_W)) u_shift (
    .clk(bit_clk), .rst_n(rst_i), .load(load), .par_in(payload), .ser_o(sdata_out));

  // R7: nothing is driven after the last payload slot
  a_r7_tail_zero: assert property (@(posedge bit_clk) disable iff (!rst_i)
    (pos > PW'(PAYLOAD_W) || pos == '0) |-> !sdata_out);
  // R1: the strobe rises only on the first bit of a frame
  a_r1_sync_start: assert property (@(posedge bit_clk) disable iff (!rst_i)
    $rose(sync) |-> (pos == PW'(1)));
endmodule

// File: tb/sim_aclink_out_framer.sv
module sim_aclink_out_framer;
  logic        bit_clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_read = 0;
  logic [1:0]  req_codec = 0;
  logic [6:0]  req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        lv = 0, rv = 0;
  logic [19:0] pl = 0, pr = 0;
  logic        req_ready, sync, sdata_out;

  int checks = 0, errors = 0;
  logic [95:0] expq[$];
  event frame_start;

  always #5 bit_clk = ~bit_clk;

  aclink_out_framer u0 (
    .bit_clk(bit_clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_codec(req_codec), .req_addr(req_addr), .req_wdata(req_wdata),
    .pcm_left_valid(lv), .pcm_left(pl), .pcm_right_valid(rv), .pcm_right(pr),
    .sync(sync), .sdata_out(sdata_out));

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected payload built from R2..R6 and R9
  function automatic logic [95:0] exp_frame(bit cmd, bit rd, bit [1:0] cid, bit [6:0] a,
      bit [15:0] d, bit l_v, bit [19:0] l, bit r_v, bit [19:0] r);
    logic [15:0] s0;
    logic [19:0] s1, s2;
    s0 = '0;
    s0[15] = cmd | l_v | r_v;
    s0[12] = l_v;
    s0[11] = r_v;
    if (cmd && cid == 2'b00) begin
      s0[14] = 1'b1;
      s0[13] = !rd;
    end else if (cmd) s0[1:0] = cid;
    s1 = cmd ? {rd, a, 12'h000} : 20'h0;
    s2 = (cmd && !rd) ? {d, 4'h0} : 20'h0;
    return {s0, s1, s2, l_v ? l : 20'h0, r_v ? r : 20'h0};
  endfunction

  // Monitor: collects one frame per strobe rise and compares against the queue
  logic         prev_sync = 0;
  bit           collecting = 0;
  int           idx = 0;
  logic [255:0] fbits, sbits;
  logic [95:0]  e;
  always @(negedge bit_clk) begin
    if (!collecting && sync && !prev_sync) begin
      collecting = 1;
      idx = 0;
      ->frame_start;
    end
    if (collecting) begin
      fbits[255-idx] = sdata_out;
      sbits[255-idx] = sync;
      idx++;
      if (idx == 256) begin
        collecting = 0;
        e = (expq.size() > 0) ? expq.pop_front() : 'x;
        chk(fbits[255:160] === e, "R2/R3/R4/R5/R6/R9 payload", {160'b0, fbits[255:160]}, {160'b0, e});
        chk(fbits[159:0] == '0, "R7 tail zero", {96'b0, fbits[159:0]}, '0);
        chk(sbits == {16'hFFFF, 240'b0}, "R1 sync pattern", sbits, {16'hFFFF, 240'b0});
      end
    end
    prev_sync = sync;
  end

  // Driver: stimulus for the frame after the one just started
  task automatic send(bit cmd, bit rd, bit [1:0] cid, bit [6:0] a, bit [15:0] d,
      bit l_v, bit [19:0] l, bit r_v, bit [19:0] r, bit poke);
    @(frame_start);
    @(negedge bit_clk);
    chk(req_ready === 1'b1, "R8 ready after boundary", {255'b0, req_ready}, 256'd1);
    lv = l_v; pl = l; rv = r_v; pr = r;
    if (cmd) begin
      req_valid = 1; req_read = rd; req_codec = cid; req_addr = a; req_wdata = d;
      @(negedge bit_clk);
      chk(req_ready === 1'b0, "R8 ready low when held", {255'b0, req_ready}, 256'd0);
      if (poke) begin
        req_read = !rd; req_codec = ~cid; req_addr = ~a; req_wdata = ~d;
        repeat (3) @(negedge bit_clk);
      end
      req_valid = 0;
    end
    expq.push_back(exp_frame(cmd, rd, cid, a, d, l_v, l, r_v, r));
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bit_clk);
    // R10 reset state
    chk(sync === 0 && sdata_out === 0 && req_ready === 1, "R10 reset outputs",
        {253'b0, sync, sdata_out, req_ready}, 256'd1);
    expq.push_back('0);  // R9 first frame is idle
    rst_n = 1;
    send(1, 0, 2'b00, 7'h2C, 16'hBEEF, 1, 20'hABCDE, 1, 20'h12345, 0); // R3 primary write
    send(1, 1, 2'b00, 7'h7F, 16'h0000, 0, 20'h0,     0, 20'h0,     0); // R3 primary read
    send(1, 0, 2'b01, 7'h02, 16'h8001, 1, 20'hFFFFF, 0, 20'h0,     1); // R4 secondary write, R8 poke
    send(1, 1, 2'b10, 7'h55, 16'h1234, 0, 20'h0,     1, 20'h80001, 0); // R4 secondary read
    send(1, 0, 2'b11, 7'h01, 16'hFFFF, 1, 20'h00001, 1, 20'hFFFFF, 0); // R4 R5 codec 3
    send(0, 0, 2'b00, 7'h00, 16'h0000, 0, 20'h0,     1, 20'h5A5A5, 0); // R6 R9 right only
    send(0, 0, 2'b00, 7'h00, 16'h0000, 0, 20'h0,     0, 20'h0,     0); // R9 idle
    send(1, 0, 2'b00, 7'h40, 16'h7FFE, 0, 20'h0,     0, 20'h0,     1); // R3 R8 poke primary
    send(0, 0, 2'b00, 7'h00, 16'h0000, 0, 20'h0,     0, 20'h0,     0); // R9 idle
    for (int i = 0; i < 2000 && expq.size() > 0; i++) @(negedge bit_clk);
    chk(expq.size() == 0, "R1 all frames produced", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule